// File: doc/BRIEF.md
# Nested-loop stream address generator

This block is a single stream data mover. Software programs up to four nested loop levels (iteration counts, per-level jumps and a repeat count) through a small configuration register port. The generator then produces a sequence of 32-bit memory word addresses on a valid/ready handshake, together with a flag that says whether the stream reads or writes memory.

The jump stored for each level already cancels the distance covered by the loops inside it. On every advance the generator adds exactly one stored jump: the one for the innermost level that can still count up. Counts are held minus one. Writing one of the eight pointer registers loads the base address, picks the number of active levels and the direction, and launches the stream in one step. Several movers may share one configuration bus. Each mover answers to its own index, and all movers accept writes sent to the broadcast index.

Top module: `stream_addr_gen`

## Requirements
- R1: The configuration address holds the register index in bits [9:5] and the mover index in bits [4:0]. Writes are accepted when the mover index equals MOVER_ID (default 0) or 31. Reads return data only for MOVER_ID and return zero for any other index.
- R2: Register 1 holds the repeat count minus one. Registers 2..5 hold the iteration counts minus one for levels 0 (innermost) to 3. Registers 6..9 hold the level jumps. All of them read back what was written.
- R3: A write to register 24+d or 28+d (d = 0..3) loads the base address and activates d+1 levels. It starts a read stream (addr_write_o = 0) for 24+d or a write stream (addr_write_o = 1) for 28+d. The first address is the written value.
- R4: After the last repeat of an address, the generator finds the innermost active level whose counter is below its limit. It adds that level's jump to the address, increments that counter and clears all inner counters.
- R5: Each address is presented repeat+1 times before the generator advances.
- R6: The handshake that completes the last address of the last repeat ends the stream. Status register 0 then reads bit0 busy = 0, bit1 done = 1, bit2 = direction and bits[4:3] = number of active levels minus one. A new launch clears done.
- R7: Configuration writes are ignored while the mover is busy.
- R8: While addr_valid_o is high and addr_ready_i is low, the address, the loop counters and the repeat counter hold.
- R9: While en_i is low, addr_valid_o stays low and the loop state is kept, so the stream resumes where it stopped.
- R10: After reset the mover is idle, addr_valid_o is low and every register reads zero.
- R11: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global stream enable |
| cfg_addr_i | input | 10 | Register index [9:5], mover index [4:0] |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data (combinational) |
| addr_o | output | 32 | Stream word address |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Address accepted by consumer |
| addr_write_o | output | 1 | 1 = write stream, 0 = read stream |

## Verification
The assertions assume that software sets up counts and jumps before it writes a pointer, and that the consumer never observes state changes while the mover is busy except through the handshake. The stimulus always configures a mover completely before launching it. It toggles en_i and addr_ready_i at random during the stream, and sends stray writes only to a foreign mover index or during a busy stream, where they must be ignored. Iteration counts stay between 1 and 3 per level, so every stream ends well inside the run.

// File: rtl/stream_addr_gen.sv
module stream_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int MOVER_ID = 0,
  parameter int BCAST_ID = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [9:0]        cfg_addr_i,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic              addr_write_o
);
  localparam int NLVL = 4;
  localparam int LW   = $clog2(NLVL);

  logic [CNT_W-1:0]  lim_q [NLVL];
  logic [CNT_W-1:0]  cnt_q [NLVL];
  logic [ADDR_W-1:0] jump_q [NLVL];
  logic [CNT_W-1:0]  rpt_max_q, rpt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LW-1:0]     dims_q;
  logic              busy_q, done_q, dir_q;

  logic [4:0] reg_idx, mv_idx;
  assign reg_idx = cfg_addr_i[9:5];
  assign mv_idx  = cfg_addr_i[4:0];

  logic wr_ok, fire, last_rpt;
  assign wr_ok    = cfg_we_i && !busy_q && (mv_idx == 5'(MOVER_ID) || mv_idx == 5'(BCAST_ID));
  assign fire     = addr_valid_o && addr_ready_i;
  assign last_rpt = (rpt_q == rpt_max_q);

  logic          adv_found;
  logic [LW-1:0] adv_lvl;
  always_comb begin
    adv_found = 1'b0;
    adv_lvl   = '0;
    for (int k = NLVL-1; k >= 0; k--) begin
      if (k <= int'(dims_q) && cnt_q[k] != lim_q[k]) begin
        adv_found = 1'b1;
        adv_lvl   = LW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NLVL; k++) begin
        lim_q[k]  <= '0;
        cnt_q[k]  <= '0;
        jump_q[k] <= '0;
      end
      rpt_max_q <= '0;
      rpt_q     <= '0;
      addr_q    <= '0;
      dims_q    <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      dir_q     <= 1'b0;
    end else if (fire) begin
      if (!last_rpt) begin
        rpt_q <= rpt_q + 1'b1;
      end else begin
        rpt_q <= '0;
        if (adv_found) begin
          addr_q <= addr_q + jump_q[adv_lvl];
          for (int k = 0; k < NLVL; k++) begin
            if (k < int'(adv_lvl))       cnt_q[k] <= '0;
            else if (k == int'(adv_lvl)) cnt_q[k] <= cnt_q[k] + 1'b1;
          end
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end else if (wr_ok) begin
      if (reg_idx == 5'd1) begin
        rpt_max_q <= cfg_wdata_i[CNT_W-1:0];
      end else if (reg_idx >= 5'd2 && reg_idx <= 5'd5) begin
        lim_q[reg_idx - 5'd2] <= cfg_wdata_i[CNT_W-1:0];
      end else if (reg_idx >= 5'd6 && reg_idx <= 5'd9) begin
        jump_q[reg_idx - 5'd6] <= cfg_wdata_i[ADDR_W-1:0];
      end else if (reg_idx >= 5'd24) begin
        addr_q <= cfg_wdata_i[ADDR_W-1:0];
        dims_q <= reg_idx[LW-1:0];
        dir_q  <= reg_idx[2];
        busy_q <= 1'b1;
        done_q <= 1'b0;
        rpt_q  <= '0;
        for (int k = 0; k < NLVL; k++) cnt_q[k] <= '0;
      end
    end
  end

  assign addr_o       = addr_q;
  assign addr_write_o = dir_q;
  assign addr_valid_o = busy_q && en_i;

  always_comb begin
    cfg_rdata_o = '0;
    if (mv_idx == 5'(MOVER_ID)) begin
      if (reg_idx == 5'd0)
        cfg_rdata_o = 32'({dims_q, dir_q, done_q, busy_q});
      else if (reg_idx == 5'd1)
        cfg_rdata_o = 32'(rpt_max_q);
      else if (reg_idx >= 5'd2 && reg_idx <= 5'd5)
        cfg_rdata_o = 32'(lim_q[reg_idx - 5'd2]);
      else if (reg_idx >= 5'd6 && reg_idx <= 5'd9)
        cfg_rdata_o = 32'(jump_q[reg_idx - 5'd6]);
      else if (reg_idx >= 5'd24)
        cfg_rdata_o = 32'(addr_q);
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=> ($stable(addr_o) && $stable(rpt_q) && $stable(cnt_q[0])));

  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !en_i) |=> ($stable(addr_o) && $stable(rpt_q) && busy_q));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cfg_we_i && !fire) |=> ($stable(rpt_max_q) && $stable(jump_q[0]) && $stable(lim_q[0])));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (done_q && !addr_valid_o));

  assert_rpt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rpt_q <= rpt_max_q));

  for (genvar g = 0; g < NLVL; g++) begin : g_chk
    assert_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q[g] <= lim_q[g]));
  end
endmodule

// File: tb/sim_stream_addr_gen.sv
module sim_stream_addr_gen;
  logic clk = 0, rst_n = 0, en_i = 0, cfg_we_i = 0, addr_ready_i = 0;
  logic [9:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0, cfg_rdata_o, addr_o;
  logic addr_valid_o, addr_write_o;

  stream_addr_gen u0 (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int bn[4];
  logic [31:0] st[4];
  logic [31:0] exq[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int r, int mv, logic [31:0] v);
    cfg_addr_i = 10'((r << 5) | mv);
    cfg_wdata_i = v;
    cfg_we_i = 1;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic rd(int r, int mv, output logic [31:0] v);
    cfg_addr_i = 10'((r << 5) | mv);
    #1 v = cfg_rdata_o;
  endtask

  function automatic void build(int dims, int rep, logic [31:0] base);
    int c[4];
    exq.delete();
    for (int k = 0; k < 4; k++) c[k] = (k <= dims) ? bn[k] : 1;
    for (int i3 = 0; i3 < c[3]; i3++)
      for (int i2 = 0; i2 < c[2]; i2++)
        for (int i1 = 0; i1 < c[1]; i1++)
          for (int i0 = 0; i0 < c[0]; i0++)
            for (int r = 0; r < rep; r++)
              exq.push_back(base + 32'(i0)*st[0] + 32'(i1)*st[1] + 32'(i2)*st[2] + 32'(i3)*st[3]);
  endfunction

  task automatic setup(int dims, int rep, int mv);
    logic [31:0] acc = 0;
    wr(1, mv, 32'(rep - 1));
    for (int k = 0; k < 4; k++) begin
      wr(2 + k, mv, 32'(bn[k] - 1));
      wr(6 + k, mv, st[k] - acc);
      acc += st[k] * 32'(bn[k] - 1);
    end
    wr(1, 1, 32'd7);
    wr(3, 1, 32'd9);
  endtask

  task automatic drain(int dims, bit dir, bit rnd);
    int got = 0, cyc = 0, bad = 0;
    logic [31:0] ba = 0, be = 0, s;
    while (got < exq.size() && cyc < 8000) begin
      en_i = rnd ? (($urandom % 4) != 0) : 1'b1;
      addr_ready_i = rnd ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (addr_valid_o && addr_ready_i) begin
        if ((addr_o !== exq[got] || addr_write_o !== dir) && bad == 0) begin
          bad = 1; ba = addr_o; be = exq[got];
        end
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    addr_ready_i = 0; en_i = 1;
    check(bad == 0 && got == exq.size(), "R4 R5 R1 R11 address sequence", ba, be);
    rd(0, 0, s);
    check(s == 32'({2'(dims), dir, 1'b1, 1'b0}) && !addr_valid_o, "R6 status after end",
          s, 32'({2'(dims), dir, 1'b1, 1'b0}));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, 0, v); check(v == 0 && !addr_valid_o, "R10 reset status", v, 0);
    rd(2, 0, v); check(v == 0, "R10 reset bound", v, 0);

    wr(5, 0, 32'd5); rd(5, 0, v); check(v == 5, "R2 bound readback", v, 5);
    wr(1, 31, 32'd2); rd(1, 0, v); check(v == 2, "R2 R1 repeat broadcast", v, 2);
    wr(1, 2, 32'd6); rd(1, 0, v); check(v == 2, "R1 foreign write ignored", v, 2);
    rd(1, 1, v); check(v == 0, "R1 foreign read zero", v, 0);

    bn = '{3, 1, 1, 1}; st = '{32'd4, 0, 0, 0};
    setup(0, 1, 0);
    wr(24, 0, 32'hFFFF_FFF8);
    check(addr_o == 32'hFFFF_FFF8 && !addr_write_o, "R3 launch read base", addr_o, 32'hFFFF_FFF8);
    build(0, 1, 32'hFFFF_FFF8);
    drain(0, 1'b0, 1'b0);
    check(exq[2] == 0, "R11 wrap model", exq[2], 0);

    bn = '{2, 2, 1, 1}; st = '{32'd8, 32'd100, 0, 0};
    setup(1, 2, 31);
    wr(29, 31, 32'h1000);
    rd(0, 0, v); check(v == 32'({2'd1, 1'b1, 1'b0, 1'b1}), "R3 R6 busy status", v, 32'h0d);
    wr(1, 0, 32'd5); rd(1, 0, v); check(v == 1, "R7 write while busy", v, 1);
    en_i = 1; addr_ready_i = 0;
    @(negedge clk); a0 = addr_o;
    repeat (3) @(negedge clk);
    check(addr_o == a0 && addr_valid_o, "R8 hold under backpressure", addr_o, a0);
    en_i = 0; #1;
    check(!addr_valid_o, "R9 enable low suppresses valid", 32'(addr_valid_o), 0);
    @(negedge clk); en_i = 1; #1;
    check(addr_valid_o && addr_o == a0, "R9 resume", addr_o, a0);
    build(1, 2, 32'h1000);
    drain(1, 1'b1, 1'b0);

    for (int t = 0; t < 30; t++) begin
      int d = $urandom % 4, rp = 1 + $urandom % 3, mv = ($urandom % 2) ? 31 : 0;
      bit dr = $urandom % 2;
      logic [31:0] base = $urandom;
      for (int k = 0; k < 4; k++) begin
        bn[k] = 1 + $urandom % 3;
        st[k] = ($urandom % 4 == 0) ? $urandom : 32'($signed(32'($urandom % 64)) - 32);
      end
      setup(d, rp, mv);
      wr((dr ? 28 : 24) + d, mv, base);
      build(d, rp, base);
      drain(d, dr, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule